// File: doc/BRIEF.md
# Serial EEPROM Target Write Front End

This block sits between the two-wire bus pins of a serial EEPROM target and the engine that programs the array. It oversamples the clock and data lines with the system clock and recognises START and STOP conditions. It assembles bytes MSB first and pulls the data line low in each acknowledge slot it grants. It then works through the write command: a control byte carrying a fixed device code, the three chip-select bits and a direction bit, then two word-address bytes, then any number of data bytes.

The downstream write engine receives three single-cycle events. The first loads the 13-bit word address, the second delivers each data byte, and the third reports the STOP that closes a selected write, which is where the engine starts its internal programming cycle. While that cycle runs the engine holds `busy_i` high, and during that time the block grants no acknowledge at all. A master polling the device therefore sees a NACK until programming finishes. Read commands and clock stretching are not handled.

Top module: `ee_wr_front`

## Requirements
- R1: A START is the data line falling while the clock line is high, and a STOP is the data line rising while the clock line is high. After reset the open-drain enable is low and no event output is active.
- R2: Data bits are taken on rising clock-line edges. The first bit received is bit 7 of the byte.
- R3: A control byte is accepted when bits 7..4 equal 1010, bits 3..1 equal `sel_i`, and bit 0 is 0 (write). An accepted byte is acknowledged: `sda_oe_o` rises after the clock falling edge that ends bit 0 and falls after the falling edge that ends the ninth clock.
- R4: A control byte with a different device code, different select bits, or bit 0 equal to 1 is not acknowledged. After it, no byte is acknowledged and no event is produced until the next START.
- R5: The byte after an accepted control byte is the address high byte, and the byte after that is the address low byte. Both are acknowledged. After the low byte, `addr_load_o` pulses for one cycle with `addr_o` = {high[4:0], low}; bits 7..5 of the high byte are ignored.
- R6: Every byte after the address low byte is acknowledged and produces a one-cycle `data_valid_o` pulse with the byte on `data_o`. There is no limit on the number of such bytes.
- R7: A STOP that arrives after an accepted control byte produces one `stop_o` pulse and returns the block to idle. A STOP in any other state produces no pulse.
- R8: If `busy_i` is high when a byte completes, that byte is not acknowledged and produces no event, and the block stays idle until the next START.
- R9: A START received at any point, including in the middle of a command, restarts reception at the control byte.
- R10: `sda_oe_o` only rises while the synchronised clock line is low. At most one event output is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sel_i | input | 3 | Chip-select strap value |
| busy_i | input | 1 | Write engine busy with an internal cycle |
| sda_oe_o | output | 1 | Open-drain pull-down enable for the data line |
| addr_load_o | output | 1 | One-cycle word address load |
| addr_o | output | 13 | Word address, valid with addr_load_o |
| data_valid_o | output | 1 | One-cycle data byte strobe |
| data_o | output | 8 | Data byte, valid with data_valid_o |
| stop_o | output | 1 | STOP closing a selected write |

## Verification
The bench uses a high address byte with all upper bits set. A design that kept those bits would report an address above 0x1FFF. Control bytes are sent that are wrong in only one field at a time: device code, select bits, or direction bit. A decoder that checked too few bits would acknowledge one of them and emit stray events. A repeated START is sent partway through the address phase. A decoder that did not restart would read the new control byte as the address low byte. `busy_i` is raised before a control byte and separately between address and data. A design that checked busy only at the control byte would acknowledge and deliver the data byte. One more sequence closes a rejected command with STOP and confirms that no spurious `stop_o` pulse appears.

// File: rtl/ee_wr_pkg.sv
// Package: shared constants and the command state type of the EEPROM
// write front end. Assumes a 4-bit device code and 8-bit bus bytes.
package ee_wr_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    // Command progress through a write transfer.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CTRL = 3'd1,
        ST_AHI  = 3'd2,
        ST_ALO  = 3'd3,
        ST_DATA = 3'd4
    } ee_state_t;

    // Bit engine phase within one byte frame.
    typedef enum logic [1:0] {
        PH_BITS = 2'd0,
        PH_WAIT = 2'd1,
        PH_ACK  = 2'd2
    } ee_phase_t;

endpackage

// File: rtl/ee_line_sync.sv
// Module: brings the two bus lines into the clock domain and derives
// clock edges plus START and STOP pulses. Assumes bus lines idle high
// and stay stable for several system clocks around each change.
module ee_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            // Synchroniser chain for one bus line, idle level high.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    // Previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s    = synced[0];
    assign sda_s    = synced[1];
    assign scl_rise = synced[0] & ~prev[0];
    assign scl_fall = ~synced[0] & prev[0];
    assign start_p  = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_p   = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/ee_bit_shift.sv
// Module: per-byte bit engine. It counts eight rising clock edges,
// shifts data MSB first, and drives the acknowledge slot when asked.
// Assumes the decoder presents its acknowledge decision in the same
// cycle as byte_done.
module ee_bit_shift
    import ee_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              ack_now,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_nx,
    output logic              ack_pend,
    output logic              sda_oe
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0]    shreg;
    logic [BIT_CNT_W-1:0] cnt;
    ee_phase_t            phase;

    assign byte_nx   = {shreg[BYTE_W-2:0], sda_s};
    assign byte_done = scl_rise && (phase == PH_BITS) && (cnt == LAST_BIT);

    // Bit counting, shifting and acknowledge slot sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            cnt      <= '0;
            phase    <= PH_BITS;
            ack_pend <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (start_p || stop_p) begin
            cnt      <= '0;
            phase    <= PH_BITS;
            ack_pend <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            case (phase)
                PH_BITS: begin
                    if (scl_rise) begin
                        shreg <= byte_nx;
                        if (cnt == LAST_BIT) begin
                            cnt      <= '0;
                            phase    <= PH_WAIT;
                            ack_pend <= ack_now;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_WAIT: begin
                    if (scl_fall) begin
                        sda_oe <= ack_pend;
                        phase  <= PH_ACK;
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        sda_oe   <= 1'b0;
                        ack_pend <= 1'b0;
                        phase    <= PH_BITS;
                    end
                end
                default: phase <= PH_BITS;
            endcase
        end
    end

endmodule

// File: rtl/ee_cmd_decode.sv
// Module: command decoder. It checks the control byte, gathers the
// two address bytes, and emits events for the write engine. Assumes
// byte_done is one cycle wide and that byte_nx is valid with it.
module ee_cmd_decode
    import ee_wr_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b1010,
    parameter int         SEL_W    = 3,
    parameter int         ADDR_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_nx,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              busy_i,
    output logic              ack_now,
    output ee_state_t         state,
    output logic              addr_load_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              data_valid_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              stop_o
);

    localparam int HI_KEEP = ADDR_W - BYTE_W;

    logic              ctrl_ok;
    logic [HI_KEEP-1:0] hi_q;

    assign ctrl_ok = (byte_nx[BYTE_W-1 -: 4] == DEV_CODE)
                  && (byte_nx[SEL_W:1] == sel_i)
                  && (byte_nx[0] == 1'b0);

    // Acknowledge decision for the byte completing this cycle.
    always_comb begin
        ack_now = 1'b0;
        if (byte_done && !busy_i) begin
            case (state)
                ST_CTRL:                  ack_now = ctrl_ok;
                ST_AHI, ST_ALO, ST_DATA:  ack_now = 1'b1;
                default:                  ack_now = 1'b0;
            endcase
        end
    end

    // Command state and downstream event generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            hi_q         <= '0;
            addr_load_o  <= 1'b0;
            addr_o       <= '0;
            data_valid_o <= 1'b0;
            data_o       <= '0;
            stop_o       <= 1'b0;
        end else begin
            addr_load_o  <= 1'b0;
            data_valid_o <= 1'b0;
            stop_o       <= 1'b0;
            if (start_p) begin
                state <= ST_CTRL;
            end else if (stop_p) begin
                stop_o <= (state == ST_AHI) || (state == ST_ALO) || (state == ST_DATA);
                state  <= ST_IDLE;
            end else if (byte_done) begin
                if (!ack_now) begin
                    state <= ST_IDLE;
                end else begin
                    case (state)
                        ST_CTRL: state <= ST_AHI;
                        ST_AHI: begin
                            hi_q  <= byte_nx[HI_KEEP-1:0];
                            state <= ST_ALO;
                        end
                        ST_ALO: begin
                            addr_o      <= {hi_q, byte_nx};
                            addr_load_o <= 1'b1;
                            state       <= ST_DATA;
                        end
                        ST_DATA: begin
                            data_o       <= byte_nx;
                            data_valid_o <= 1'b1;
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/ee_wr_front.sv
// Module: top of the EEPROM write front end. It joins the line
// synchroniser, the bit engine and the command decoder. Assumes the
// bus is slow relative to clk (several clocks per bus phase).
module ee_wr_front
    import ee_wr_pkg::*;
#(
    parameter logic [3:0] DEV_CODE    = 4'b1010,
    parameter int         SEL_W       = 3,
    parameter int         ADDR_W      = 13,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              busy_i,
    output logic              sda_oe_o,
    output logic              addr_load_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              data_valid_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              stop_o
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_p;
    logic              stop_p;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_nx;
    logic              ack_now;
    logic              ack_pend;
    ee_state_t         state;

    ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    ee_bit_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .ack_now   (ack_now),
        .byte_done (byte_done),
        .byte_nx   (byte_nx),
        .ack_pend  (ack_pend),
        .sda_oe    (sda_oe_o)
    );

    ee_cmd_decode #(
        .DEV_CODE (DEV_CODE),
        .SEL_W    (SEL_W),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_p      (start_p),
        .stop_p       (stop_p),
        .byte_done    (byte_done),
        .byte_nx      (byte_nx),
        .sel_i        (sel_i),
        .busy_i       (busy_i),
        .ack_now      (ack_now),
        .state        (state),
        .addr_load_o  (addr_load_o),
        .addr_o       (addr_o),
        .data_valid_o (data_valid_o),
        .data_o       (data_o),
        .stop_o       (stop_o)
    );

endmodule

// File: rtl/ee_wr_front_chk.sv
// Checker: temporal properties of the write front end, bound to the top.
module ee_wr_front_chk
    import ee_wr_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_s,
    input logic      start_p,
    input logic      stop_p,
    input logic      byte_done,
    input logic      busy_i,
    input logic      ack_pend,
    input logic      sda_oe_o,
    input logic      addr_load_o,
    input logic      data_valid_o,
    input logic      stop_o,
    input ee_state_t state
);

    p_oe_rise_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s);

    p_events_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_load_o, data_valid_o, stop_o}));

    p_busy_blocks_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && busy_i) |=> !ack_pend);

    p_stop_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (!sda_oe_o && state == ST_IDLE));

    p_stop_one_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

    p_start_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> (state == ST_CTRL));

endmodule

bind ee_wr_front ee_wr_front_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_s        (scl_s),
    .start_p      (start_p),
    .stop_p       (stop_p),
    .byte_done    (byte_done),
    .busy_i       (busy_i),
    .ack_pend     (ack_pend),
    .sda_oe_o     (sda_oe_o),
    .addr_load_o  (addr_load_o),
    .data_valid_o (data_valid_o),
    .stop_o       (stop_o),
    .state        (state)
);

// File: tb/ee_wr_front_tb.sv
// Bench: a bus-master driver with a scoreboard of expected events.
module ee_wr_front_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        int kind;
        int val;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  sel = 3'b101;
    logic        busy = 1'b0;
    logic        sda_oe;
    logic        sda_line;
    logic        addr_load;
    logic [12:0] addr;
    logic        data_valid;
    logic [7:0]  data;
    logic        stop_ev;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   cycles   = 0;
    ev_t  exp_q[$];

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    ee_wr_front u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .sel_i        (sel),
        .busy_i       (busy),
        .sda_oe_o     (sda_oe),
        .addr_load_o  (addr_load),
        .addr_o       (addr),
        .data_valid_o (data_valid),
        .data_o       (data),
        .stop_o       (stop_ev)
    );

    task automatic check(input string req, input int act, input int exp_v, input string what);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic push(input int kind, input int val);
        ev_t e;
        e.kind = kind;
        e.val  = val;
        exp_q.push_back(e);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_clk(HALF);
        scl = 1'b1;
        wait_clk(HALF);
        sda_m = 1'b0;
        wait_clk(HALF);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_clk(HALF);
        scl = 1'b1;
        wait_clk(HALF);
        sda_m = 1'b1;
        wait_clk(HALF);
    endtask

    // Sends a byte MSB first and checks the acknowledge slot.
    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            wait_clk(HALF);
            scl = 1'b1;
            wait_clk(HALF);
            scl = 1'b0;
        end
        sda_m = 1'b1;
        wait_clk(HALF);
        scl = 1'b1;
        wait_clk(HALF/2);
        @(negedge clk);
        check(req, int'(!sda_line), int'(exp_ack), "ack slot");
        wait_clk(HALF/2);
        scl = 1'b0;
    endtask

    // Monitor: pops an expected event for every event pulse seen.
    always @(negedge clk) begin
        if (rst_n && (addr_load || data_valid || stop_ev)) begin
            int kind;
            int val;
            kind = addr_load ? 1 : (data_valid ? 2 : 3);
            val  = addr_load ? int'(addr) : (data_valid ? int'(data) : 0);
            if (exp_q.size() == 0) begin
                check("R4", kind, 0, "unexpected event kind");
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                check("R6", kind, e.kind, "event kind");
                check("R5", val, e.val, "event value");
            end
        end
    end

    // Watchdog against a hung run.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        @(negedge clk);
        // R1: idle after reset
        check("R1", int'(sda_oe), 0, "oe after reset");
        check("R1", int'({addr_load, data_valid, stop_ev}), 0, "events after reset");

        // R2 R3 R5 R6 R7: full write, upper address bits set
        bus_start();
        send_byte(8'hAA, 1'b1, "R3");
        send_byte(8'hFF, 1'b1, "R5");
        push(1, 13'h1F34);
        send_byte(8'h34, 1'b1, "R5");
        push(2, 8'h5A);
        send_byte(8'h5A, 1'b1, "R2");
        push(2, 8'hC3);
        send_byte(8'hC3, 1'b1, "R6");
        push(2, 8'h00);
        send_byte(8'h00, 1'b1, "R6");
        push(3, 0);
        bus_stop();

        // R4: wrong device code, then no acks and no STOP event
        bus_start();
        send_byte(8'hBA, 1'b0, "R4");
        send_byte(8'h00, 1'b0, "R4");
        send_byte(8'h11, 1'b0, "R4");
        bus_stop();

        // R4: wrong select bits
        bus_start();
        send_byte(8'hA2, 1'b0, "R4");
        bus_stop();

        // R4: read direction bit
        bus_start();
        send_byte(8'hAB, 1'b0, "R4");
        send_byte(8'h00, 1'b0, "R4");
        bus_stop();

        // R9: repeated START after the high address byte
        bus_start();
        send_byte(8'hAA, 1'b1, "R9");
        send_byte(8'h00, 1'b1, "R9");
        bus_start();
        send_byte(8'hAA, 1'b1, "R9");
        send_byte(8'h12, 1'b1, "R9");
        push(1, 13'h1201);
        send_byte(8'h01, 1'b1, "R9");
        push(2, 8'h77);
        send_byte(8'h77, 1'b1, "R9");
        push(3, 0);
        bus_stop();

        // R8: busy before control byte
        busy = 1'b1;
        bus_start();
        send_byte(8'hAA, 1'b0, "R8");
        bus_stop();

        // R8: busy raised between address and data
        busy = 1'b0;
        bus_start();
        send_byte(8'hAA, 1'b1, "R8");
        send_byte(8'h03, 1'b1, "R8");
        push(1, 13'h0321);
        send_byte(8'h21, 1'b1, "R8");
        busy = 1'b1;
        send_byte(8'h99, 1'b0, "R8");
        busy = 1'b0;
        send_byte(8'h98, 1'b0, "R8");
        bus_stop();

        // R3: other select strap value
        sel = 3'b000;
        bus_start();
        send_byte(8'hA0, 1'b1, "R3");
        send_byte(8'hE0, 1'b1, "R5");
        push(1, 13'h0000);
        send_byte(8'h00, 1'b1, "R5");
        push(3, 0);
        bus_stop();

        wait_clk(20);
        // R7: every expected event arrived
        check("R7", exp_q.size(), 0, "pending events");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule